// File: doc/BRIEF.md
# Fabric Link Idle-Handshake Controller

This block manages the start-up handshake of a cell-based switch-fabric link. On the transmit side it tells the idle-frame generator whether to send idle frames and what to advertise in their control-ready and data-ready flags. It also decides when normal control and data cells may flow. On the receive side it accepts a decoded "idle frame arrived" strobe, latches a sticky status bit when the far end is heard, and raises an interrupt if that is enabled.

Out of reset the egress override is active, so any idle frames carry both ready flags low. Host software enables idle transmission and idle reception, then waits for the status bit or the interrupt. It then either clears the override, which makes both flags go high, or keeps the override and drives the two flags directly from override bits 7 and 6. Finally it enables control and data cells. A new flag value reaches the generator only at an idle-frame boundary, so no frame carries mixed values.

The host reaches the registers over a simple bus: a write strobe with an address and write data, and read data that is decoded from the address in the same cycle. Register offsets are: 0 transmit control (bit0 enable, bit1 idle, bit2 control-cell enable, bit3 data-cell enable), 1 receive control (bit0 idle receive enable), 2 override (bit0 egress force, bit1 ingress force, bit6 data-ready, bit7 control-ready), 3 status (bit0 idle seen, write 1 to clear), and 4 interrupt enable (bit0). Unmapped offsets and unused bits read as 0.

Top module: `fabric_idle_ctl`

## Requirements
- R1: After reset the override register reads 0x01 and every other register reads 0x00. `idle_cready`, `idle_dready`, `idle_send`, `traffic_en`, `ingress_force` and `irq` are all 0.
- R2: `idle_send` is 1 exactly when transmit control bit0 (enable) and bit1 (idle) are both 1.
- R3: While override bit0 (egress force) is 1 and override bits 7:6 are 00, the ready flags stay 0 across frame boundaries.
- R4: `idle_cready` and `idle_dready` change only in the cycle after a cycle in which `frame_start` is 1. Register writes alone do not move them.
- R5: After override bit0 is cleared, the next frame boundary sets both ready flags to 1.
- R6: While override bit0 is 1, a frame boundary loads `idle_cready` from override bit7 and `idle_dready` from override bit6.
- R7: `rx_idle_stb` has no effect on status bit0 while receive control bit0 is 0.
- R8: With receive control bit0 at 1, an `rx_idle_stb` pulse makes status bit0 read 1 from the next cycle on.
- R9: `irq` is 1 exactly when status bit0 and interrupt-enable bit0 are both 1.
- R10: Status bit0 is sticky. Writing 1 to bit0 clears it, and writing 0 leaves it unchanged. A later accepted idle frame sets it again, and a set in the same cycle as a clear wins.
- R11: `traffic_en` is 1 only when transmit control bits 0, 2 and 3 are all 1.
- R12: `ingress_force` follows override bit1, which resets to 0; writing it to 0 releases ingress forcing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_wen | input | 1 | Host register write strobe |
| hb_addr | input | 3 | Host register offset |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data for `hb_addr` |
| frame_start | input | 1 | Idle-frame boundary strobe from the generator |
| rx_idle_stb | input | 1 | Decoded idle-frame-received strobe |
| idle_send | output | 1 | Generator should emit idle frames |
| idle_cready | output | 1 | Control-ready flag carried by idle frames |
| idle_dready | output | 1 | Data-ready flag carried by idle frames |
| traffic_en | output | 1 | Control and data cell paths are open |
| ingress_force | output | 1 | Ingress-side forcing active |
| irq | output | 1 | Idle-detected interrupt |

## Verification
A stuck or corrupted override or ready-flag register shows up on `idle_cready`/`idle_dready` one cycle after the next `frame_start`. A flag that moves without a boundary shows up as soon as a register is written. A wrong sticky status bit appears on `irq` and on the status read in the cycle after the strobe or the clear. A gating error appears at once on `idle_send` or `traffic_en`, because both decode the stored control bits without delay. The directed scenarios change one register at a time, so every such fault reaches a port within one or two cycles of the stimulus that exposes it.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] OFS_TXCTL = 3'd0;
  localparam logic [REG_AW-1:0] OFS_RXCTL = 3'd1;
  localparam logic [REG_AW-1:0] OFS_OVRD  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_ISTAT = 3'd3;
  localparam logic [REG_AW-1:0] OFS_IEN   = 3'd4;

  // writable-bit masks and reset values
  localparam logic [REG_DW-1:0] MSK_TXCTL = 8'h0F;
  localparam logic [REG_DW-1:0] MSK_RXCTL = 8'h01;
  localparam logic [REG_DW-1:0] MSK_OVRD  = 8'hC3;
  localparam logic [REG_DW-1:0] MSK_IEN   = 8'h01;
  localparam logic [REG_DW-1:0] RST_OVRD  = 8'h01;

  // field positions
  localparam int unsigned TX_EN_B   = 0;
  localparam int unsigned TX_IDLE_B = 1;
  localparam int unsigned TX_CC_B   = 2;
  localparam int unsigned TX_CD_B   = 3;
  localparam int unsigned OV_EG_B   = 0;
  localparam int unsigned OV_IN_B   = 1;
  localparam int unsigned OV_DR_B   = 6;
  localparam int unsigned OV_CR_B   = 7;
endpackage

// File: rtl/fic_regs.sv
module fic_regs
  import fic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              idle_hit,
  output logic [REG_DW-1:0] rdata,
  output logic              tx_en,
  output logic              tx_idle,
  output logic              tx_cc,
  output logic              tx_cd,
  output logic              rx_en,
  output logic              eg_force,
  output logic              in_force,
  output logic              ovr_cr,
  output logic              ovr_dr,
  output logic              ien_idle,
  output logic              stat_idle
);
  logic [REG_DW-1:0] txctl_q, txctl_d;
  logic [REG_DW-1:0] rxctl_q, rxctl_d;
  logic [REG_DW-1:0] ovrd_q,  ovrd_d;
  logic [REG_DW-1:0] ien_q,   ien_d;
  logic              stat_q,  stat_d;
  logic              clr_hit;

  assign clr_hit = wen && (addr == OFS_ISTAT) && wdata[0];

  always_comb begin
    txctl_d = txctl_q;
    rxctl_d = rxctl_q;
    ovrd_d  = ovrd_q;
    ien_d   = ien_q;
    if (wen) begin
      case (addr)
        OFS_TXCTL: txctl_d = wdata & MSK_TXCTL;
        OFS_RXCTL: rxctl_d = wdata & MSK_RXCTL;
        OFS_OVRD:  ovrd_d  = wdata & MSK_OVRD;
        OFS_IEN:   ien_d   = wdata & MSK_IEN;
        default:   ;
      endcase
    end
    stat_d = stat_q;
    if (clr_hit)  stat_d = 1'b0;
    if (idle_hit) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txctl_q <= '0;
      rxctl_q <= '0;
      ovrd_q  <= RST_OVRD;
      ien_q   <= '0;
      stat_q  <= 1'b0;
    end else begin
      txctl_q <= txctl_d;
      rxctl_q <= rxctl_d;
      ovrd_q  <= ovrd_d;
      ien_q   <= ien_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_TXCTL: rdata = txctl_q;
      OFS_RXCTL: rdata = rxctl_q;
      OFS_OVRD:  rdata = ovrd_q;
      OFS_ISTAT: rdata = {{(REG_DW-1){1'b0}}, stat_q};
      OFS_IEN:   rdata = ien_q;
      default:   rdata = '0;
    endcase
  end

  assign tx_en     = txctl_q[TX_EN_B];
  assign tx_idle   = txctl_q[TX_IDLE_B];
  assign tx_cc     = txctl_q[TX_CC_B];
  assign tx_cd     = txctl_q[TX_CD_B];
  assign rx_en     = rxctl_q[0];
  assign eg_force  = ovrd_q[OV_EG_B];
  assign in_force  = ovrd_q[OV_IN_B];
  assign ovr_cr    = ovrd_q[OV_CR_B];
  assign ovr_dr    = ovrd_q[OV_DR_B];
  assign ien_idle  = ien_q[0];
  assign stat_idle = stat_q;

  // R8
  idle_hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> stat_q);

  // R10
  idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_hit) |=> stat_q);

  // R7
  idle_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q && !idle_hit) |=> !stat_q);
endmodule

// File: rtl/fic_tx_ready.sv
module fic_tx_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic tx_en,
  input  logic tx_idle,
  input  logic tx_cc,
  input  logic tx_cd,
  input  logic eg_force,
  input  logic ovr_cr,
  input  logic ovr_dr,
  output logic idle_send,
  output logic cready,
  output logic dready,
  output logic traffic_en
);
  logic cr_q, cr_d, dr_q, dr_d;
  logic cr_tgt, dr_tgt;

  // forced: flags come from the override bits; released: both high
  assign cr_tgt = eg_force ? ovr_cr : 1'b1;
  assign dr_tgt = eg_force ? ovr_dr : 1'b1;

  always_comb begin
    cr_d = cr_q;
    dr_d = dr_q;
    if (frame_start) begin
      cr_d = cr_tgt;
      dr_d = dr_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= 1'b0;
      dr_q <= 1'b0;
    end else begin
      cr_q <= cr_d;
      dr_q <= dr_d;
    end
  end

  assign cready     = cr_q;
  assign dready     = dr_q;
  assign idle_send  = tx_en && tx_idle;
  assign traffic_en = tx_en && tx_cc && tx_cd;

  // R4
  flags_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cr_q) && $stable(dr_q)));

  // R3
  forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && eg_force && !ovr_cr && !ovr_dr) |=> (!cr_q && !dr_q));

  // R5
  released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !eg_force) |=> (cr_q && dr_q));
endmodule

// File: rtl/fic_rx_detect.sv
module fic_rx_detect (
  input  logic rx_en,
  input  logic rx_idle_stb,
  input  logic stat_idle,
  input  logic ien_idle,
  output logic idle_hit,
  output logic irq
);
  assign idle_hit = rx_en && rx_idle_stb;
  assign irq      = stat_idle && ien_idle;
endmodule

// File: rtl/fabric_idle_ctl.sv
module fabric_idle_ctl
  import fic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_wen,
  input  logic [REG_AW-1:0] hb_addr,
  input  logic [REG_DW-1:0] hb_wdata,
  output logic [REG_DW-1:0] hb_rdata,
  input  logic              frame_start,
  input  logic              rx_idle_stb,
  output logic              idle_send,
  output logic              idle_cready,
  output logic              idle_dready,
  output logic              traffic_en,
  output logic              ingress_force,
  output logic              irq
);
  logic tx_en, tx_idle, tx_cc, tx_cd, rx_en;
  logic eg_force, in_force, ovr_cr, ovr_dr;
  logic ien_idle, stat_idle, idle_hit;

  fic_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wen       (hb_wen),
    .addr      (hb_addr),
    .wdata     (hb_wdata),
    .idle_hit  (idle_hit),
    .rdata     (hb_rdata),
    .tx_en     (tx_en),
    .tx_idle   (tx_idle),
    .tx_cc     (tx_cc),
    .tx_cd     (tx_cd),
    .rx_en     (rx_en),
    .eg_force  (eg_force),
    .in_force  (in_force),
    .ovr_cr    (ovr_cr),
    .ovr_dr    (ovr_dr),
    .ien_idle  (ien_idle),
    .stat_idle (stat_idle)
  );

  fic_tx_ready u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .tx_en       (tx_en),
    .tx_idle     (tx_idle),
    .tx_cc       (tx_cc),
    .tx_cd       (tx_cd),
    .eg_force    (eg_force),
    .ovr_cr      (ovr_cr),
    .ovr_dr      (ovr_dr),
    .idle_send   (idle_send),
    .cready      (idle_cready),
    .dready      (idle_dready),
    .traffic_en  (traffic_en)
  );

  fic_rx_detect u_rx (
    .rx_en       (rx_en),
    .rx_idle_stb (rx_idle_stb),
    .stat_idle   (stat_idle),
    .ien_idle    (ien_idle),
    .idle_hit    (idle_hit),
    .irq         (irq)
  );

  assign ingress_force = in_force;

  // R9
  irq_needs_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq)) |-> $past(rx_idle_stb || hb_wen));
endmodule

// File: tb/fabric_idle_ctl_tb_top.sv
`timescale 1ns/1ps
module fabric_idle_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hb_wen = 1'b0;
  logic [2:0] hb_addr = 3'd0;
  logic [7:0] hb_wdata = 8'd0;
  logic [7:0] hb_rdata;
  logic       frame_start = 1'b0;
  logic       rx_idle_stb = 1'b0;
  logic       idle_send, idle_cready, idle_dready, traffic_en, ingress_force, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fabric_idle_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .hb_wen(hb_wen), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .frame_start(frame_start),
    .rx_idle_stb(rx_idle_stb), .idle_send(idle_send), .idle_cready(idle_cready),
    .idle_dready(idle_dready), .traffic_en(traffic_en),
    .ingress_force(ingress_force), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    hb_wen = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_wen = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [7:0] exp);
    @(negedge clk);
    hb_addr = a;
    #1;
    check(req, hb_rdata, exp);
  endtask

  task automatic boundary();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic rx_pulse();
    @(negedge clk);
    rx_idle_stb = 1'b1;
    @(negedge clk);
    rx_idle_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    rd_check("R1 ovrd", 3'd2, 8'h01);
    rd_check("R1 txctl", 3'd0, 8'h00);
    rd_check("R1 rxctl", 3'd1, 8'h00);
    rd_check("R1 istat", 3'd3, 8'h00);
    rd_check("R1 ien", 3'd4, 8'h00);
    check("R1 outs", {2'b0, idle_send, idle_cready, idle_dready, traffic_en, ingress_force, irq}, 8'h00);
  endtask

  task automatic t_idle_gate();
    wr(3'd0, 8'h02); check("R2 idle only", {7'b0, idle_send}, 8'h0);
    wr(3'd0, 8'h01); check("R2 en only", {7'b0, idle_send}, 8'h0);
    wr(3'd0, 8'h03); check("R2 both", {7'b0, idle_send}, 8'h1);
  endtask

  task automatic t_forced_low();
    boundary();
    boundary();
    check("R3 forced low", {6'b0, idle_cready, idle_dready}, 8'h0);
  endtask

  task automatic t_override_bits();
    wr(3'd2, 8'h81);
    check("R4 no move on write", {6'b0, idle_cready, idle_dready}, 8'h0);
    boundary();
    check("R6 bit7 only", {6'b0, idle_cready, idle_dready}, 8'h2);
    wr(3'd2, 8'h41); boundary();
    check("R6 bit6 only", {6'b0, idle_cready, idle_dready}, 8'h1);
    wr(3'd2, 8'hC1); boundary();
    check("R6 both", {6'b0, idle_cready, idle_dready}, 8'h3);
    wr(3'd2, 8'h01);
    check("R4 hold until boundary", {6'b0, idle_cready, idle_dready}, 8'h3);
    boundary();
    check("R3 back low", {6'b0, idle_cready, idle_dready}, 8'h0);
  endtask

  task automatic t_release();
    wr(3'd2, 8'h00);
    check("R4 release waits", {6'b0, idle_cready, idle_dready}, 8'h0);
    boundary();
    check("R5 released high", {6'b0, idle_cready, idle_dready}, 8'h3);
  endtask

  task automatic t_rx_gate();
    wr(3'd4, 8'h01);
    rx_pulse();
    rd_check("R7 ignored", 3'd3, 8'h00);
    check("R7 no irq", {7'b0, irq}, 8'h0);
  endtask

  task automatic t_detect_irq();
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h01);
    rx_pulse();
    rd_check("R8 seen", 3'd3, 8'h01);
    check("R9 masked", {7'b0, irq}, 8'h0);
    wr(3'd4, 8'h01);
    check("R9 enabled", {7'b0, irq}, 8'h1);
  endtask

  task automatic t_w1c();
    wr(3'd3, 8'h00);
    rd_check("R10 write0 keeps", 3'd3, 8'h01);
    wr(3'd3, 8'h01);
    rd_check("R10 cleared", 3'd3, 8'h00);
    check("R10 irq drop", {7'b0, irq}, 8'h0);
    rx_pulse();
    rd_check("R10 set again", 3'd3, 8'h01);
    @(negedge clk);
    hb_wen = 1'b1; hb_addr = 3'd3; hb_wdata = 8'h01; rx_idle_stb = 1'b1;
    @(negedge clk);
    hb_wen = 1'b0; rx_idle_stb = 1'b0;
    rd_check("R10 set wins", 3'd3, 8'h01);
  endtask

  task automatic t_traffic();
    wr(3'd0, 8'h07); check("R11 no data", {7'b0, traffic_en}, 8'h0);
    wr(3'd0, 8'h0B); check("R11 no ctl", {7'b0, traffic_en}, 8'h0);
    wr(3'd0, 8'h0E); check("R11 no en", {7'b0, traffic_en}, 8'h0);
    wr(3'd0, 8'h0F); check("R11 all", {7'b0, traffic_en}, 8'h1);
    rd_check("R11 readback", 3'd0, 8'h0F);
  endtask

  task automatic t_ingress();
    wr(3'd2, 8'h02); check("R12 set", {7'b0, ingress_force}, 8'h1);
    wr(3'd2, 8'h00); check("R12 released", {7'b0, ingress_force}, 8'h0);
    rd_check("R12 readback", 3'd2, 8'h00);
  endtask

  initial begin
    t_reset();
    t_idle_gate();
    t_forced_low();
    t_override_bits();
    t_release();
    t_rx_gate();
    t_detect_irq();
    t_w1c();
    t_traffic();
    t_ingress();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule